// File: doc/BRIEF.md
# Clamping-Diode Fault Switching-State Remapper

This block sits between the modulator and the gate drivers of one five-level neutral-point-clamped leg. On each state-change strobe the modulator hands it a switching state from 1 to 9. The block registers the eight gate levels that realise the state at its outputs. If no clamping-diode fault has been recorded, the state passes through unchanged.

A diagnosis unit reports a failed diode pair on a load strobe, and the block latches it. From then on, any requested state whose current path needs the failed pair is replaced by a state that produces the same terminal level without that pair, so the leg keeps delivering full-rated output. A configuration input chooses which of the two neutral-point-free zero states replaces the middle state. A requested state outside the legal range blanks all gates and raises an error flag.

Top module: `diode_fault_remapper`

## Requirements
- R1: During and right after a synchronous active-low reset, `gates`, `state_out` and `state_err` are all zero and the mode is healthy.
- R2: In healthy mode, a strobe with a legal request (1..9) registers `state_out` equal to the request, whatever `zero_sel` is.
- R3: `gates` bit 7 down to bit 0 drive S11,S12,S13,S14,S21,S22,S23,S24. The states encode as 1=11000011, 2=11000110, 3=01100011, 4=11001100, 5=01100110, 6=00110011, 7=01101100, 8=00110110, 9=00111100. Whenever any gate is on, S13=~S11, S14=~S12, S22=~S24 and S21=~S23.
- R4: In upper-pair-failed mode (code 1), state 3 is sent as 2, state 5 as the zero state, and state 7 as 8. All other states pass unchanged.
- R5: In lower-pair-failed mode (code 2), state 2 is sent as 3, state 5 as the zero state, and state 8 as 7. All other states pass unchanged.
- R6: The zero state is 4 when `zero_sel`=0 and 6 when `zero_sel`=1, sampled on the same strobe. `zero_sel` has no effect in healthy mode.
- R7: `diode_code` is latched on `diode_load` only while the mode is healthy. Code 0 keeps the healthy mode and code 3 is ignored. Once a failed mode is latched, further loads are ignored until reset.
- R8: `gates`, `state_out` and `state_err` change only on a cycle where `state_stb` is high. A mode change without a strobe leaves them as they were.
- R9: A strobe with a request of 0 or 10..15 sets all gates and `state_out` to zero and sets `state_err`. The next strobe with a legal request clears `state_err`.
- R10: When `diode_load` and `state_stb` are high in the same cycle, the strobe is mapped with the mode held before that load. The new mode applies from the next strobe on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| diode_load | input | 1 | Load strobe for the fault code |
| diode_code | input | 2 | 0 healthy, 1 upper pair failed, 2 lower pair failed, 3 reserved |
| zero_sel | input | 1 | Zero-level state choice: 0 uses state 4, 1 uses state 6 |
| state_stb | input | 1 | Modulator state-change strobe |
| state_req | input | 4 | Requested switching state |
| gates | output | 8 | Gate levels S11..S24, MSB first |
| state_out | output | 4 | Switching state actually applied, 0 when blanked |
| state_err | output | 1 | Last strobed request was outside 1..9 |

## Verification
A fault-code load and a state strobe can land in the same clock cycle. The order between them decides whether that switching interval still uses the healthy mapping. The bench provokes this by raising both strobes together on states the load will remap, such as 7 with an upper-pair code. It expects the unmodified state on that strobe and the substituted state on the following one. Random runs mix loads, strobes, idle cycles and illegal requests at arbitrary spacings, and a bench model tracks the latched mode to judge each result.

// File: rtl/remap_pkg.sv
// Package: shared widths, fault-mode type and half-leg position helpers.
// Assumes states are coded 1..9; any other value is illegal.
package remap_pkg;

    localparam int STATE_W    = 4;
    localparam int CODE_W     = 2;
    localparam int LEG_W      = 4;
    localparam int NUM_LEGS   = 2;
    localparam int GATE_W     = LEG_W * NUM_LEGS;
    localparam int NUM_STATES = 9;

    typedef enum logic [CODE_W-1:0] {
        MODE_HEALTHY    = 2'd0,
        MODE_UPPER_FAIL = 2'd1,
        MODE_LOWER_FAIL = 2'd2
    } fault_mode_e;

    typedef logic [1:0] leg_pos_t;

    // Position of the upper half-leg: 0 = top pair on, 1 = middle, 2 = bottom pair on.
    function automatic leg_pos_t upper_pos(input logic [STATE_W-1:0] s);
        case (s)
            4'd1, 4'd2, 4'd4: upper_pos = 2'd0;
            4'd3, 4'd5, 4'd7: upper_pos = 2'd1;
            4'd6, 4'd8, 4'd9: upper_pos = 2'd2;
            default:          upper_pos = 2'd0;
        endcase
    endfunction

    // Position of the lower half-leg, same meaning as for the upper half-leg.
    function automatic leg_pos_t lower_pos(input logic [STATE_W-1:0] s);
        case (s)
            4'd4, 4'd7, 4'd9: lower_pos = 2'd0;
            4'd2, 4'd5, 4'd8: lower_pos = 2'd1;
            4'd1, 4'd3, 4'd6: lower_pos = 2'd2;
            default:          lower_pos = 2'd0;
        endcase
    endfunction

    // Terminal level in half-link steps (-2..+2) derived from the two leg positions.
    function automatic logic signed [2:0] term_level(input logic [STATE_W-1:0] s);
        term_level = $signed({1'b0, lower_pos(s)}) - $signed({1'b0, upper_pos(s)});
    endfunction

    // True for the legal request range 1..NUM_STATES.
    function automatic logic state_legal(input logic [STATE_W-1:0] s);
        state_legal = (s != '0) && (s <= STATE_W'(NUM_STATES));
    endfunction

endpackage

// File: rtl/fault_mode_latch.sv
// Fault mode latch: captures the diagnosed diode-pair code on a load strobe.
// Assumes a load is accepted only while healthy; a failed mode is sticky until reset.
module fault_mode_latch
    import remap_pkg::*;
#(
    parameter int CW = CODE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] code,
    output fault_mode_e   mode
);

    fault_mode_e mode_q;
    logic        code_ok;

    // Decide whether the offered code names a real mode.
    always_comb code_ok = (code == CW'(MODE_UPPER_FAIL)) || (code == CW'(MODE_LOWER_FAIL));

    // Hold the latched mode; accept a failed-pair code only from healthy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_HEALTHY;
        end else if (load && code_ok && (mode_q == MODE_HEALTHY)) begin
            mode_q <= fault_mode_e'(code);
        end
    end

    assign mode = mode_q;

    // R7
    mode_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != MODE_HEALTHY) |=> (mode_q == $past(mode_q)));

    // R7
    mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_HEALTHY) || (mode_q == MODE_UPPER_FAIL) || (mode_q == MODE_LOWER_FAIL));

endmodule

// File: rtl/state_substitute.sv
// State substitution: replaces states that route current through a failed pair.
// Assumes combinational use; the caller registers the result on its strobe.
module state_substitute
    import remap_pkg::*;
#(
    parameter int SW = STATE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  fault_mode_e   mode,
    input  logic          zero_sel,
    input  logic [SW-1:0] req,
    output logic [SW-1:0] mapped,
    output logic          invalid
);

    logic [SW-1:0] zero_state;

    // Pick which neutral-point-free state stands in for the middle state.
    always_comb zero_state = zero_sel ? SW'(6) : SW'(4);

    // Map the request according to the latched fault mode.
    always_comb begin
        invalid = !state_legal(req);
        mapped  = req;
        unique case (mode)
            MODE_UPPER_FAIL: begin
                if (req == SW'(3))      mapped = SW'(2);
                else if (req == SW'(5)) mapped = zero_state;
                else if (req == SW'(7)) mapped = SW'(8);
            end
            MODE_LOWER_FAIL: begin
                if (req == SW'(2))      mapped = SW'(3);
                else if (req == SW'(5)) mapped = zero_state;
                else if (req == SW'(8)) mapped = SW'(7);
            end
            default: mapped = req;
        endcase
        if (invalid) mapped = '0;
    end

    // R4
    upper_avoid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_UPPER_FAIL && !invalid) |->
        (mapped != SW'(3) && mapped != SW'(5) && mapped != SW'(7)));

    // R5
    lower_avoid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_LOWER_FAIL && !invalid) |->
        (mapped != SW'(2) && mapped != SW'(5) && mapped != SW'(8)));

    // R4 R5 R6
    level_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !invalid |-> (term_level(mapped) == term_level(req)));

endmodule

// File: rtl/gate_encoder.sv
// Gate encoder: turns a switching state into the eight gate levels.
// Assumes bits 7..4 are the upper half-leg and bits 3..0 the lower one.
module gate_encoder
    import remap_pkg::*;
#(
    parameter int SW = STATE_W,
    parameter int LW = LEG_W,
    parameter int NL = NUM_LEGS
) (
    input  logic [SW-1:0]    state,
    output logic [LW*NL-1:0] gates
);

    localparam int            GW        = LW * NL;
    localparam logic [LW-1:0] BASE_PAT  = {2'b11, {(LW-2){1'b0}}};

    logic valid;

    // Flag whether the state can be driven at all.
    always_comb valid = state_legal(state);

    for (genvar g = 0; g < NL; g++) begin : g_leg
        leg_pos_t pos;
        // Select the position of this half-leg.
        always_comb pos = (g == 0) ? upper_pos(state) : lower_pos(state);
        // Slide the on-pair down by the position; blank when not legal.
        assign gates[GW-1-g*LW -: LW] = valid ? (BASE_PAT >> pos) : '0;
    end

endmodule

// File: rtl/diode_fault_remapper.sv
// Top: remaps modulator states around a failed clamping-diode pair and
// registers the gate outputs on each state-change strobe.
// Assumes dead-time insertion is done downstream.
module diode_fault_remapper
    import remap_pkg::*;
#(
    parameter int SW = STATE_W,
    parameter int CW = CODE_W,
    parameter int GW = GATE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          diode_load,
    input  logic [CW-1:0] diode_code,
    input  logic          zero_sel,
    input  logic          state_stb,
    input  logic [SW-1:0] state_req,
    output logic [GW-1:0] gates,
    output logic [SW-1:0] state_out,
    output logic          state_err
);

    fault_mode_e   mode;
    logic [SW-1:0] mapped;
    logic          invalid;
    logic [GW-1:0] enc_gates;
    logic [GW-1:0] gates_q;
    logic [SW-1:0] state_q;
    logic          err_q;

    fault_mode_latch #(.CW(CW)) u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (diode_load),
        .code  (diode_code),
        .mode  (mode)
    );

    state_substitute #(.SW(SW)) u_sub (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .zero_sel (zero_sel),
        .req      (state_req),
        .mapped   (mapped),
        .invalid  (invalid)
    );

    gate_encoder #(.SW(SW), .LW(LEG_W), .NL(NUM_LEGS)) u_enc (
        .state (mapped),
        .gates (enc_gates)
    );

    // Register the applied state only on a modulator strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gates_q <= '0;
            state_q <= '0;
            err_q   <= 1'b0;
        end else if (state_stb) begin
            gates_q <= enc_gates;
            state_q <= mapped;
            err_q   <= invalid;
        end
    end

    assign gates     = gates_q;
    assign state_out = state_q;
    assign state_err = err_q;

    // R8
    hold_no_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !state_stb |=> ($stable(gates_q) && $stable(state_q) && $stable(err_q)));

    // R3
    comp_pairs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gates_q != '0) |->
        (gates_q[5] != gates_q[7] && gates_q[4] != gates_q[6] &&
         gates_q[2] != gates_q[0] && gates_q[3] != gates_q[1]));

    // R3
    four_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gates_q == '0) || ($countones(gates_q) == 4));

    // R9
    err_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> (gates_q == '0 && state_q == '0));

endmodule

// File: tb/tb_diode_fault_remapper.sv
module tb_diode_fault_remapper;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       diode_load;
    logic [1:0] diode_code;
    logic       zero_sel;
    logic       state_stb;
    logic [3:0] state_req;
    logic [7:0] gates;
    logic [3:0] state_out;
    logic       state_err;

    int checks = 0;
    int errors = 0;
    int bm_mode = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    diode_fault_remapper dut (
        .clk(clk), .rst_n(rst_n), .diode_load(diode_load), .diode_code(diode_code),
        .zero_sel(zero_sel), .state_stb(state_stb), .state_req(state_req),
        .gates(gates), .state_out(state_out), .state_err(state_err)
    );

    function automatic logic [7:0] exp_gates(input logic [3:0] s);
        case (s)
            4'd1: exp_gates = 8'b1100_0011;
            4'd2: exp_gates = 8'b1100_0110;
            4'd3: exp_gates = 8'b0110_0011;
            4'd4: exp_gates = 8'b1100_1100;
            4'd5: exp_gates = 8'b0110_0110;
            4'd6: exp_gates = 8'b0011_0011;
            4'd7: exp_gates = 8'b0110_1100;
            4'd8: exp_gates = 8'b0011_0110;
            4'd9: exp_gates = 8'b0011_1100;
            default: exp_gates = 8'h00;
        endcase
    endfunction

    function automatic logic [3:0] exp_state(input int mode, input logic [3:0] r, input logic zs);
        logic [3:0] z;
        z = zs ? 4'd6 : 4'd4;
        if (r == 0 || r > 9) return 4'd0;
        if (mode == 1) begin
            if (r == 3) return 4'd2;
            if (r == 5) return z;
            if (r == 7) return 4'd8;
        end else if (mode == 2) begin
            if (r == 2) return 4'd3;
            if (r == 5) return z;
            if (r == 8) return 4'd7;
        end
        return r;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_out(input string tag, input logic [3:0] es, input logic ee);
        chk({tag, " state"}, state_out, es);
        chk({tag, " gates"}, gates, exp_gates(es));
        chk({tag, " err"}, state_err, ee);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; diode_load = 0; state_stb = 0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        bm_mode = 0;
    endtask

    task automatic do_load(input logic [1:0] c);
        @(negedge clk);
        diode_code = c; diode_load = 1'b1;
        @(negedge clk);
        diode_load = 1'b0;
        if (bm_mode == 0 && (c == 1 || c == 2)) bm_mode = c;
    endtask

    // Strobe a request; optionally load a code in the same cycle (R10).
    task automatic do_strobe(input string tag, input logic [3:0] r, input logic zs,
                             input logic with_load, input logic [1:0] c);
        logic [3:0] es;
        @(negedge clk);
        state_req = r; zero_sel = zs; state_stb = 1'b1;
        diode_load = with_load; diode_code = c;
        es = exp_state(bm_mode, r, zs);
        @(negedge clk);
        state_stb = 1'b0; diode_load = 1'b0;
        if (with_load && bm_mode == 0 && (c == 1 || c == 2)) bm_mode = c;
        chk_out(tag, es, (r == 0 || r > 9));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [3:0] hs;
        logic       he;
        void'($urandom(32'h1234_5EED));
        rst_n = 0; diode_load = 0; diode_code = 0; zero_sel = 0; state_stb = 0; state_req = 0;
        do_reset();
        // R1 reset state
        chk_out("R1 reset", 4'd0, 1'b0);

        // R2 R3 healthy pass-through, every state, both zero_sel values (R6 no effect)
        for (int s = 1; s <= 9; s++) begin
            do_strobe("R2 R3 healthy", 4'(s), 1'b0, 1'b0, 2'd0);
            do_strobe("R6 healthy zsel", 4'(s), 1'b1, 1'b0, 2'd0);
        end

        // R9 illegal requests, then clearing
        do_strobe("R9 req0", 4'd0, 1'b0, 1'b0, 2'd0);
        do_strobe("R9 req12", 4'd12, 1'b1, 1'b0, 2'd0);
        do_strobe("R9 clear", 4'd9, 1'b0, 1'b0, 2'd0);

        // R8 hold without strobe while request changes
        state_req = 4'd1;
        repeat (3) @(negedge clk);
        chk_out("R8 hold", 4'd9, 1'b0);

        // R7 reserved code ignored
        do_load(2'd3);
        do_strobe("R7 code3 ignored", 4'd3, 1'b0, 1'b0, 2'd0);

        // R10 load and strobe together: old mapping, then new
        do_strobe("R10 same cycle", 4'd7, 1'b0, 1'b1, 2'd1);
        do_strobe("R10 next strobe", 4'd7, 1'b0, 1'b0, 2'd0);

        // R4 R6 upper-pair mapping
        for (int s = 1; s <= 9; s++) begin
            do_strobe("R4 upper zs0", 4'(s), 1'b0, 1'b0, 2'd0);
            do_strobe("R4 R6 upper zs1", 4'(s), 1'b1, 1'b0, 2'd0);
        end
        // R7 later load ignored
        do_load(2'd2);
        do_strobe("R7 sticky", 4'd2, 1'b0, 1'b0, 2'd0);

        // R5 lower-pair mapping
        do_reset();
        do_load(2'd2);
        for (int s = 1; s <= 9; s++) begin
            do_strobe("R5 lower zs0", 4'(s), 1'b0, 1'b0, 2'd0);
            do_strobe("R5 R6 lower zs1", 4'(s), 1'b1, 1'b0, 2'd0);
        end

        // R8 mode change without strobe leaves outputs
        do_reset();
        do_strobe("R8 pre", 4'd5, 1'b0, 1'b0, 2'd0);
        do_load(2'd1);
        repeat (2) @(negedge clk);
        chk_out("R8 mode change held", 4'd5, 1'b0);
        do_strobe("R8 post", 4'd5, 1'b1, 1'b0, 2'd0);

        // Random phase
        for (int seg = 0; seg < 4; seg++) begin
            do_reset();
            hs = 4'd0; he = 1'b0;
            for (int i = 0; i < 200; i++) begin
                int pick;
                logic [3:0] r;
                pick = int'($urandom_range(0, 99));
                r = ($urandom_range(0, 9) < 8) ? 4'($urandom_range(1, 9)) : 4'($urandom_range(0, 15));
                if (pick < 8) begin
                    do_load(2'($urandom_range(0, 3)));
                    chk_out("R7 R8 rand load", hs, he);
                end else if (pick < 15) begin
                    do_strobe("R10 rand", r, 1'($urandom_range(0, 1)), 1'b1, 2'($urandom_range(0, 3)));
                    hs = state_out; he = state_err;
                end else if (pick < 22) begin
                    state_req = r;
                    @(negedge clk);
                    chk_out("R8 rand idle", hs, he);
                end else begin
                    do_strobe("R2 R4 R5 R9 rand", r, 1'($urandom_range(0, 1)), 1'b0, 2'd0);
                    hs = state_out; he = state_err;
                end
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule